// File: doc/BRIEF.md
# Fast-Clock FIFO Occupancy Flag Generator

This block keeps track of how many words sit in an asynchronous FIFO whose write side and read side run on unrelated clocks. Neither port pointer crosses to the other side. Instead, each accepted access is reduced to a toggle in its own port domain. A third, free-running fast clock samples both toggles, turns every toggle edge into a one-cycle event and feeds the events to an up/down occupancy counter.

The counter value is compared with two run-time offsets. The result is an almost-full indication for the writer and an almost-empty indication for the reader. Both comparisons are registered in the fast domain and then carried into the port clock that consumes them.

The fast clock must run at least three times faster than the faster port clock. With that margin, back-to-back accesses on either port are each counted once. The FIFO storage and its data path are not part of this block.

Top module: `occ_flag_gen`

## Requirements
- R1: While `rst` is high and after its release, with no access made, `count` is 0, `wr_almost_full` is 0 and `rd_almost_empty` is 1.
- R2: Every rising edge of `wr_clk` at which `wr_en` is 1 raises `count` by exactly one, including writes on consecutive `wr_clk` cycles.
- R3: Every rising edge of `rd_clk` at which `rd_en` is 1 lowers `count` by exactly one, including reads on consecutive `rd_clk` cycles.
- R4: When writes and reads run at the same time on their own clocks, the settled `count` equals writes minus reads. A write event and a read event that fall in the same fast cycle leave `count` unchanged.
- R5: Once settled, `wr_almost_full` is 1 exactly when `count` >= `DEPTH` - `full_ofs`. This includes the boundary values `count` = `DEPTH` - `full_ofs` (flag set) and one below it (flag clear).
- R6: Once settled, `rd_almost_empty` is 1 exactly when `count` <= `empty_ofs`. This includes the boundary values `count` = `empty_ofs` (flag set) and one above it (flag clear).
- R7: `count` moves by at most one step per `fast_clk` cycle and never exceeds `DEPTH`.
- R8: A change of `full_ofs` or `empty_ofs` with no access pending is reflected on the port flags after a few fast and port cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write accepted this `wr_clk` cycle |
| rd_clk | input | 1 | Read port clock |
| rd_en | input | 1 | Read accepted this `rd_clk` cycle |
| fast_clk | input | 1 | Free-running counting clock, at least 3x the faster port clock |
| rst | input | 1 | Active-high reset, sampled synchronously in every domain |
| full_ofs | input | CNT_W | Distance below `DEPTH` at which almost-full sets |
| empty_ofs | input | CNT_W | Occupancy at or below which almost-empty sets |
| count | output | CNT_W | Words held, in the `fast_clk` domain |
| wr_almost_full | output | 1 | Almost-full flag, synchronous to `wr_clk` |
| rd_almost_empty | output | 1 | Almost-empty flag, synchronous to `rd_clk` |

## Verification
The counter is driven in four ways:
- Write-only bursts on consecutive write cycles show whether an edge is lost or doubled in the toggle crossing.
- Read-only bursts check the decrement path on its own.
- Overlapping write and read streams on the two unrelated clocks force events into the same fast cycle now and then, which exposes a wrong hold or step rule.
- Walking the count across both thresholds, and then moving the offsets while no access is made, separates off-by-one compare errors from flags that fail to follow offset changes.

// File: rtl/occ_pkg.sv
`timescale 1ns/1ps
package occ_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic logic reach_top(input int unsigned cnt, input int unsigned depth,
                                     input int unsigned ofs);
    return (cnt + ofs) >= depth;
  endfunction

  function automatic logic reach_bottom(input int unsigned cnt, input int unsigned ofs);
    return cnt <= ofs;
  endfunction
endpackage

// File: rtl/port_toggle.sv
`timescale 1ns/1ps
module port_toggle (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tgl
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      tgl  <= 1'b0;
    end else begin
      en_q <= en;
      if (en_q) tgl <= ~tgl;
    end
  end
endmodule

// File: rtl/toggle_to_pulse.sv
`timescale 1ns/1ps
module toggle_to_pulse #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], tgl_in};
  end

  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= {STAGES{RST_VAL}};
    else     stage <= {stage[STAGES-2:0], d};
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/occ_counter.sv
`timescale 1ns/1ps
module occ_counter #(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [CNT_W-1:0] full_ofs,
  input  logic [CNT_W-1:0] empty_ofs,
  output logic [CNT_W-1:0] count,
  output logic             af,
  output logic             ae
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  logic [CNT_W:0] top_mark;
  assign top_mark = DEPTH_X - {1'b0, full_ofs};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      af <= 1'b0;
      ae <= 1'b1;
    end else begin
      af <= ({1'b0, count} >= top_mark);
      ae <= (count <= empty_ofs);
    end
  end
endmodule

// File: rtl/occ_flag_gen.sv
`timescale 1ns/1ps
module occ_flag_gen #(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic             fast_clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] full_ofs,
  input  logic [CNT_W-1:0] empty_ofs,
  output logic [CNT_W-1:0] count,
  output logic             wr_almost_full,
  output logic             rd_almost_empty
);
  import occ_pkg::*;

  logic wr_tgl, rd_tgl;
  logic wr_pulse, rd_pulse;
  logic af_fast, ae_fast;

  port_toggle u_wr_tgl (.clk(wr_clk), .rst(rst), .en(wr_en), .tgl(wr_tgl));
  port_toggle u_rd_tgl (.clk(rd_clk), .rst(rst), .en(rd_en), .tgl(rd_tgl));

  toggle_to_pulse #(.STAGES(SYNC_STAGES)) u_wr_evt (
    .clk(fast_clk), .rst(rst), .tgl_in(wr_tgl), .pulse(wr_pulse));
  toggle_to_pulse #(.STAGES(SYNC_STAGES)) u_rd_evt (
    .clk(fast_clk), .rst(rst), .tgl_in(rd_tgl), .pulse(rd_pulse));

  occ_counter #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cnt (
    .clk(fast_clk), .rst(rst), .inc(wr_pulse), .dec(rd_pulse),
    .full_ofs(full_ofs), .empty_ofs(empty_ofs),
    .count(count), .af(af_fast), .ae(ae_fast));

  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_af_sync (
    .clk(wr_clk), .rst(rst), .d(af_fast), .q(wr_almost_full));
  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ae_sync (
    .clk(rd_clk), .rst(rst), .d(ae_fast), .q(rd_almost_empty));
endmodule

// File: rtl/occ_flag_gen_chk.sv
`timescale 1ns/1ps
module occ_flag_gen_chk #(
  parameter int DEPTH = 512,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             fast_clk,
  input logic             rst,
  input logic             wr_pulse,
  input logic             rd_pulse,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] full_ofs,
  input logic [CNT_W-1:0] empty_ofs,
  input logic             af_fast,
  input logic             ae_fast
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  assert_wr_single_R2: assert property (@(posedge fast_clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);
  assert_rd_single_R3: assert property (@(posedge fast_clk) disable iff (rst)
    rd_pulse |=> !rd_pulse);
  assert_inc_R2: assert property (@(posedge fast_clk) disable iff (rst)
    (wr_pulse && !rd_pulse) |=> count == $past(count) + 1'b1);
  assert_dec_R3: assert property (@(posedge fast_clk) disable iff (rst)
    (rd_pulse && !wr_pulse) |=> count == $past(count) - 1'b1);
  assert_hold_R4: assert property (@(posedge fast_clk) disable iff (rst)
    (wr_pulse == rd_pulse) |=> $stable(count));
  assert_af_R5: assert property (@(posedge fast_clk) disable iff (rst)
    1'b1 |=> af_fast == (({1'b0, $past(count)} + {1'b0, $past(full_ofs)}) >= DEPTH_X));
  assert_ae_R6: assert property (@(posedge fast_clk) disable iff (rst)
    1'b1 |=> ae_fast == ($past(count) <= $past(empty_ofs)));
  assert_bound_R7: assert property (@(posedge fast_clk) disable iff (rst)
    {1'b0, count} <= DEPTH_X);
endmodule

bind occ_flag_gen occ_flag_gen_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .fast_clk(fast_clk), .rst(rst), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
  .count(count), .full_ofs(full_ofs), .empty_ofs(empty_ofs),
  .af_fast(af_fast), .ae_fast(ae_fast));

// File: tb/test_occ_flag_gen.sv
`timescale 1ns/1ps
module test_occ_flag_gen;
  localparam int DEPTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic wr_clk = 0, rd_clk = 0, fast_clk = 0;
  logic rst = 1, wr_en = 0, rd_en = 0;
  logic [CNT_W-1:0] full_ofs = 4, empty_ofs = 3;
  logic [CNT_W-1:0] count;
  logic wr_almost_full, rd_almost_empty;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  int prev_cnt = 0;
  bit mon_on = 0;
  bit done = 0;

  always #10 fast_clk = ~fast_clk;
  always #35 wr_clk   = ~wr_clk;
  always #45 rd_clk   = ~rd_clk;

  occ_flag_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_occ_flag_gen (
    .wr_clk(wr_clk), .wr_en(wr_en), .rd_clk(rd_clk), .rd_en(rd_en),
    .fast_clk(fast_clk), .rst(rst), .full_ofs(full_ofs), .empty_ofs(empty_ofs),
    .count(count), .wr_almost_full(wr_almost_full), .rd_almost_empty(rd_almost_empty));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle reference: count moves by at most one and stays within [0, DEPTH].
  always @(negedge fast_clk) begin
    if (mon_on && !rst) begin
      int d;
      d = int'(count) - prev_cnt;
      check("R7 step", (d >= -1 && d <= 1) ? 1 : 0, 1);
      check("R7 bound", (int'(count) <= DEPTH) ? 1 : 0, 1);
    end
    prev_cnt = int'(count);
  end

  task automatic do_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk) wr_en = 1;
      exp_cnt++;
    end
    @(negedge wr_clk) wr_en = 0;
  endtask

  task automatic do_reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk) rd_en = 1;
      exp_cnt--;
    end
    @(negedge rd_clk) rd_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    repeat (10) @(posedge fast_clk);
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    @(negedge fast_clk);
  endtask

  task automatic check_all(input string tag_cnt, input string tag_af, input string tag_ae);
    check(tag_cnt, int'(count), exp_cnt);
    check(tag_af, int'(wr_almost_full), (exp_cnt + int'(full_ofs) >= DEPTH) ? 1 : 0);
    check(tag_ae, int'(rd_almost_empty), (exp_cnt <= int'(empty_ofs)) ? 1 : 0);
  endtask

  initial begin
    repeat (6) @(posedge rd_clk);
    @(negedge fast_clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 af in reset", int'(wr_almost_full), 0);
    check("R1 ae in reset", int'(rd_almost_empty), 1);
    rst = 0;
    prev_cnt = 0;
    mon_on = 1;
    settle();
    check("R1 count after reset", int'(count), 0);
    check("R1 af after reset", int'(wr_almost_full), 0);
    check("R1 ae after reset", int'(rd_almost_empty), 1);

    do_writes(20); settle();                         // 20
    check_all("R2 burst write", "R5 af", "R6 ae");
    do_reads(5); settle();                           // 15
    check_all("R3 burst read", "R5 af", "R6 ae");

    fork do_writes(16); do_reads(3); join            // 28
    settle();
    check_all("R4 concurrent", "R5 af at threshold", "R6 ae");
    check("R5 af set at DEPTH-full_ofs", int'(wr_almost_full), 1);

    do_reads(1); settle();                           // 27
    check_all("R3 single read", "R5 af one below", "R6 ae");
    check("R5 af clear one below", int'(wr_almost_full), 0);

    fork do_writes(9); do_reads(33); join            // 3
    settle();
    check_all("R4 overlapping streams", "R5 af", "R6 ae at threshold");
    check("R6 ae set at empty_ofs", int'(rd_almost_empty), 1);

    do_writes(1); settle();                          // 4
    check_all("R2 single write", "R5 af", "R6 ae one above");
    check("R6 ae clear one above", int'(rd_almost_empty), 0);

    empty_ofs = 4; full_ofs = 28; settle();
    check_all("R8 count unchanged", "R8 af follows full_ofs", "R8 ae follows empty_ofs");
    check("R8 af raised", int'(wr_almost_full), 1);
    check("R8 ae raised", int'(rd_almost_empty), 1);
    full_ofs = 4; empty_ofs = 0; settle();
    check_all("R8 count unchanged", "R8 af lowered", "R8 ae lowered");

    do_reads(4); settle();                           // 0
    check_all("R3 drain to empty", "R5 af", "R6 ae at zero");

    do_writes(32); settle();                         // 32
    check_all("R2 fill to depth", "R5 af full", "R6 ae");

    mon_on = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule